// File: doc/BRIEF.md
# Complex-Instruction Micro-Op Sequencer

This block sits between an instruction decoder and a simple load/store execution core. It takes one decoded complex instruction at a time and expands it into a fixed, ordered list of simple micro-ops. The number of micro-ops and their order depend only on the instruction class. Memory operands, stack pushes, calls and returns each become several steps. Values that pass between those steps go through a hidden temporary register tag that software cannot name.

Micro-ops leave the block one per cycle on a valid/ready handshake. Each micro-op carries an opcode, an ALU function, a destination tag, two source tags, an immediate and an end-of-instruction flag. The input side accepts a new instruction only when no expansion is in progress. A stall on the output holds the current micro-op steady and keeps the block at the same step.

Top module: `uop_seq`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: in_ready is 0 from the cycle after an instruction is accepted until the handshake of its last micro-op. It is 1 again in the cycle after that handshake.
- R3: Class 0 (register ALU, compare or branch) emits one micro-op with op 0 (ALU). fn, rd, ra, rb and imm are passed through unchanged.
- R4: Class 1 (load) emits one micro-op: op 1, rd=in_rd, ra=in_ra, imm. Class 2 (store) emits one micro-op: op 2, ra=in_ra, rb=in_rb, imm. Unused fields are 0 in every micro-op.
- R5: Class 3 (ALU with memory source) emits two micro-ops. The first is op 1 into TEMP from ra+imm. The second is op 0 with fn, rd=in_rd, ra=in_rd, rb=TEMP.
- R6: Class 4 (ALU with memory destination) emits three micro-ops, all using the same base and displacement. The first is op 1 into TEMP. The second is op 0 with fn, rd=TEMP, ra=TEMP, rb=in_rb. The third is op 2 with ra=in_ra, rb=TEMP.
- R7: Class 5 (push) emits two micro-ops. The first is op 2 storing in_rb at SP with imm −4. The second is op 3 (add immediate) with rd=SP, ra=SP and imm −4. Immediates are two's complement.
- R8: Class 6 (call) emits four micro-ops in this order. First, op 4 (capture PC) into TEMP. Second, op 2 storing TEMP at SP−4. Third, op 3 SP+=−4. Fourth, op 5 (jump) with imm = in_imm.
- R9: Class 7 (return) emits three micro-ops in this order. First, op 3 SP+=4. Second, op 1 loading TEMP from SP−4. Third, op 6 (jump through register) with ra=TEMP.
- R10: While out_valid is 1 and out_ready is 0, every output field holds its value and the step does not advance.
- R11: out_eoi is 1 on the last micro-op of each instruction and 0 on all earlier ones.
- R12: TEMP is tag 2^REG_W−1 (15 by default) and SP is tag 2^REG_W−2 (14 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Block can take an instruction |
| in_cls | input | 3 | Instruction class 0..7 |
| in_fn | input | FN_W | ALU function |
| in_rd | input | REG_W | Destination register tag |
| in_ra | input | REG_W | Base or first source tag |
| in_rb | input | REG_W | Second source or store data tag |
| in_imm | input | IMM_W | Displacement, immediate or jump target |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_op | output | 3 | Micro-op opcode |
| out_fn | output | FN_W | ALU function (0 unless op 0) |
| out_rd | output | REG_W | Destination tag |
| out_ra | output | REG_W | First source or base tag |
| out_rb | output | REG_W | Second source or data tag |
| out_imm | output | IMM_W | Immediate |
| out_eoi | output | 1 | Last micro-op of the instruction |

## Verification
The assertions assume that in_cls and the handshake inputs are never unknown after reset. They also assume that software-visible register fields never name the hidden TEMP tag, because a jump through a register must always use TEMP. The directed bench follows both rules: it drives only tags below 14 into the register fields. It releases out_ready only inside its own micro-op collection task, so stalls happen on purpose and always between known steps.

// File: rtl/uop_seq_pkg.sv
package uop_seq_pkg;

    localparam int STEP_W = 2;
    localparam int CNT_W  = STEP_W + 1;

    typedef enum logic [2:0] {
        CLS_REG_ALU = 3'd0,
        CLS_LOAD    = 3'd1,
        CLS_STORE   = 3'd2,
        CLS_MEM_SRC = 3'd3,
        CLS_MEM_DST = 3'd4,
        CLS_PUSH    = 3'd5,
        CLS_CALL    = 3'd6,
        CLS_RET     = 3'd7
    } icls_e;

    typedef enum logic [2:0] {
        OP_ALU   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_ADDI  = 3'd3,
        OP_PCCAP = 3'd4,
        OP_JMP   = 3'd5,
        OP_JMPR  = 3'd6
    } uop_e;

    // Number of micro-ops produced by each class.
    function automatic logic [CNT_W-1:0] uop_count(icls_e c);
        case (c)
            CLS_MEM_SRC: return CNT_W'(2);
            CLS_MEM_DST: return CNT_W'(3);
            CLS_PUSH:    return CNT_W'(2);
            CLS_CALL:    return CNT_W'(4);
            CLS_RET:     return CNT_W'(3);
            default:     return CNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/uop_seq_ctrl.sv
module uop_seq_ctrl
    import uop_seq_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int IMM_W = 32,
    parameter int FN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  icls_e             in_cls,
    input  logic [FN_W-1:0]   in_fn,
    input  logic [REG_W-1:0]  in_rd,
    input  logic [REG_W-1:0]  in_ra,
    input  logic [REG_W-1:0]  in_rb,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic              out_ready,
    input  logic              last,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output icls_e             h_cls,
    output logic [FN_W-1:0]   h_fn,
    output logic [REG_W-1:0]  h_rd,
    output logic [REG_W-1:0]  h_ra,
    output logic [REG_W-1:0]  h_rb,
    output logic [IMM_W-1:0]  h_imm
);

    assign in_ready = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            step  <= '0;
            h_cls <= CLS_REG_ALU;
            h_fn  <= '0;
            h_rd  <= '0;
            h_ra  <= '0;
            h_rb  <= '0;
            h_imm <= '0;
        end else if (!busy) begin
            if (in_valid) begin
                busy  <= 1'b1;
                step  <= '0;
                h_cls <= in_cls;
                h_fn  <= in_fn;
                h_rd  <= in_rd;
                h_ra  <= in_ra;
                h_rb  <= in_rb;
                h_imm <= in_imm;
            end
        end else if (out_ready) begin
            if (last) begin
                busy <= 1'b0;
                step <= '0;
            end else begin
                step <= step + STEP_W'(1);
            end
        end
    end

endmodule

// File: rtl/uop_seq_expand.sv
module uop_seq_expand
    import uop_seq_pkg::*;
#(
    parameter int REG_W      = 4,
    parameter int IMM_W      = 32,
    parameter int FN_W       = 4,
    parameter int SLOT_BYTES = 4
) (
    input  icls_e             cls,
    input  logic [STEP_W-1:0] step,
    input  logic [FN_W-1:0]   fn,
    input  logic [REG_W-1:0]  rd,
    input  logic [REG_W-1:0]  ra,
    input  logic [REG_W-1:0]  rb,
    input  logic [IMM_W-1:0]  imm,
    output uop_e              o_op,
    output logic [FN_W-1:0]   o_fn,
    output logic [REG_W-1:0]  o_rd,
    output logic [REG_W-1:0]  o_ra,
    output logic [REG_W-1:0]  o_rb,
    output logic [IMM_W-1:0]  o_imm,
    output logic              o_eoi
);

    localparam logic [REG_W-1:0] TEMP   = {REG_W{1'b1}};
    localparam logic [REG_W-1:0] SP     = {{(REG_W-1){1'b1}}, 1'b0};
    localparam logic [IMM_W-1:0] SP_INC = IMM_W'(SLOT_BYTES);
    localparam logic [IMM_W-1:0] SP_DEC = IMM_W'(0) - IMM_W'(SLOT_BYTES);

    assign o_eoi = ({1'b0, step} == (uop_count(cls) - CNT_W'(1)));

    always_comb begin
        o_op  = OP_ALU;
        o_fn  = '0;
        o_rd  = '0;
        o_ra  = '0;
        o_rb  = '0;
        o_imm = '0;
        case (cls)
            CLS_REG_ALU: begin
                o_fn = fn; o_rd = rd; o_ra = ra; o_rb = rb; o_imm = imm;
            end
            CLS_LOAD: begin
                o_op = OP_LOAD; o_rd = rd; o_ra = ra; o_imm = imm;
            end
            CLS_STORE: begin
                o_op = OP_STORE; o_ra = ra; o_rb = rb; o_imm = imm;
            end
            CLS_MEM_SRC: begin
                if (step == 0) begin
                    o_op = OP_LOAD; o_rd = TEMP; o_ra = ra; o_imm = imm;
                end else begin
                    o_fn = fn; o_rd = rd; o_ra = rd; o_rb = TEMP;
                end
            end
            CLS_MEM_DST: begin
                case (step)
                    2'd0: begin o_op = OP_LOAD; o_rd = TEMP; o_ra = ra; o_imm = imm; end
                    2'd1: begin o_fn = fn; o_rd = TEMP; o_ra = TEMP; o_rb = rb; end
                    default: begin o_op = OP_STORE; o_ra = ra; o_rb = TEMP; o_imm = imm; end
                endcase
            end
            CLS_PUSH: begin
                if (step == 0) begin
                    o_op = OP_STORE; o_ra = SP; o_rb = rb; o_imm = SP_DEC;
                end else begin
                    o_op = OP_ADDI; o_rd = SP; o_ra = SP; o_imm = SP_DEC;
                end
            end
            CLS_CALL: begin
                case (step)
                    2'd0: begin o_op = OP_PCCAP; o_rd = TEMP; end
                    2'd1: begin o_op = OP_STORE; o_ra = SP; o_rb = TEMP; o_imm = SP_DEC; end
                    2'd2: begin o_op = OP_ADDI; o_rd = SP; o_ra = SP; o_imm = SP_DEC; end
                    default: begin o_op = OP_JMP; o_imm = imm; end
                endcase
            end
            default: begin
                case (step)
                    2'd0: begin o_op = OP_ADDI; o_rd = SP; o_ra = SP; o_imm = SP_INC; end
                    2'd1: begin o_op = OP_LOAD; o_rd = TEMP; o_ra = SP; o_imm = SP_DEC; end
                    default: begin o_op = OP_JMPR; o_ra = TEMP; end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/uop_seq.sv
module uop_seq
    import uop_seq_pkg::*;
#(
    parameter int REG_W      = 4,
    parameter int IMM_W      = 32,
    parameter int FN_W       = 4,
    parameter int SLOT_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_cls,
    input  logic [FN_W-1:0]  in_fn,
    input  logic [REG_W-1:0] in_rd,
    input  logic [REG_W-1:0] in_ra,
    input  logic [REG_W-1:0] in_rb,
    input  logic [IMM_W-1:0] in_imm,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [2:0]       out_op,
    output logic [FN_W-1:0]  out_fn,
    output logic [REG_W-1:0] out_rd,
    output logic [REG_W-1:0] out_ra,
    output logic [REG_W-1:0] out_rb,
    output logic [IMM_W-1:0] out_imm,
    output logic             out_eoi
);

    logic              busy;
    logic [STEP_W-1:0] step;
    icls_e             h_cls;
    logic [FN_W-1:0]   h_fn;
    logic [REG_W-1:0]  h_rd, h_ra, h_rb;
    logic [IMM_W-1:0]  h_imm;
    uop_e              op_e;

    uop_seq_ctrl #(.REG_W(REG_W), .IMM_W(IMM_W), .FN_W(FN_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(icls_e'(in_cls)), .in_fn(in_fn), .in_rd(in_rd), .in_ra(in_ra),
        .in_rb(in_rb), .in_imm(in_imm),
        .out_ready(out_ready), .last(out_eoi),
        .busy(busy), .step(step),
        .h_cls(h_cls), .h_fn(h_fn), .h_rd(h_rd), .h_ra(h_ra), .h_rb(h_rb), .h_imm(h_imm)
    );

    uop_seq_expand #(.REG_W(REG_W), .IMM_W(IMM_W), .FN_W(FN_W), .SLOT_BYTES(SLOT_BYTES)) u_exp (
        .cls(h_cls), .step(step), .fn(h_fn), .rd(h_rd), .ra(h_ra), .rb(h_rb), .imm(h_imm),
        .o_op(op_e), .o_fn(out_fn), .o_rd(out_rd), .o_ra(out_ra), .o_rb(out_rb),
        .o_imm(out_imm), .o_eoi(out_eoi)
    );

    assign out_valid = busy;
    assign out_op    = op_e;

endmodule

// File: rtl/uop_seq_chk.sv
module uop_seq_chk #(
    parameter int REG_W      = 4,
    parameter int IMM_W      = 32,
    parameter int FN_W       = 4,
    parameter int SLOT_BYTES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [2:0]       in_cls,
    input logic [FN_W-1:0]  in_fn,
    input logic [REG_W-1:0] in_rd,
    input logic [REG_W-1:0] in_ra,
    input logic [REG_W-1:0] in_rb,
    input logic [IMM_W-1:0] in_imm,
    input logic             out_valid,
    input logic             out_ready,
    input logic [2:0]       out_op,
    input logic [FN_W-1:0]  out_fn,
    input logic [REG_W-1:0] out_rd,
    input logic [REG_W-1:0] out_ra,
    input logic [REG_W-1:0] out_rb,
    input logic [IMM_W-1:0] out_imm,
    input logic             out_eoi
);

    localparam logic [REG_W-1:0] TEMP = {REG_W{1'b1}};

    // R2
    busy_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_fn)
            && $stable(out_rd) && $stable(out_ra) && $stable(out_rb)
            && $stable(out_imm) && $stable(out_eoi)));

    // R11
    eoi_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_eoi) |=> !out_valid);

    // R11
    mid_continues_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_eoi) |=> out_valid);

    // R12
    jmpr_temp_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_op == 3'd6) |-> (out_ra == TEMP));

endmodule

bind uop_seq uop_seq_chk #(.REG_W(REG_W), .IMM_W(IMM_W), .FN_W(FN_W), .SLOT_BYTES(SLOT_BYTES)) u_chk (.*);

// File: tb/uop_seq_tb.sv
`timescale 1ns/1ps
module uop_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_cls = '0;
    logic [3:0]  in_fn = '0, in_rd = '0, in_ra = '0, in_rb = '0;
    logic [31:0] in_imm = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [2:0]  out_op;
    logic [3:0]  out_fn, out_rd, out_ra, out_rb;
    logic [31:0] out_imm;
    logic        out_eoi;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0]  T   = 4'd15;
    localparam logic [3:0]  SP  = 4'd14;
    localparam logic [31:0] M4  = 32'hFFFF_FFFC;
    localparam logic [31:0] P4  = 32'd4;

    always #2.5 clk = ~clk;

    uop_seq u_dut (.*);

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic send(input logic [2:0] c, input logic [3:0] f, input logic [3:0] d,
                        input logic [3:0] a, input logic [3:0] b, input logic [31:0] i);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_cls = c; in_fn = f; in_rd = d; in_ra = a; in_rb = b; in_imm = i;
        in_valid = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic expect_uop(input string req, input logic [2:0] op, input logic [3:0] f,
                              input logic [3:0] d, input logic [3:0] a, input logic [3:0] b,
                              input logic [31:0] i, input logic e);
        int w;
        w = 0;
        @(negedge clk);
        while (!out_valid && w < 20) begin
            @(negedge clk);
            w++;
        end
        chk(req, {11'd0, out_valid, out_op, out_fn, out_rd, out_ra, out_rb, out_imm, out_eoi},
                 {11'd0, 1'b1, op, f, d, a, b, i, e});
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 in_ready", 64'(in_ready), 64'd1);
    endtask

    task automatic t_reg_alu();
        send(3'd0, 4'd5, 4'd1, 4'd2, 4'd3, 32'h1234);
        expect_uop("R3 alu", 3'd0, 4'd5, 4'd1, 4'd2, 4'd3, 32'h1234, 1'b1);
        send(3'd0, 4'd9, 4'd7, 4'd0, 4'd6, 32'hDEAD_BEEF);
        expect_uop("R3 alu2", 3'd0, 4'd9, 4'd7, 4'd0, 4'd6, 32'hDEAD_BEEF, 1'b1);
    endtask

    task automatic t_load_store();
        send(3'd1, 4'd3, 4'd4, 4'd5, 4'd6, 32'd16);
        expect_uop("R4 load", 3'd1, 4'd0, 4'd4, 4'd5, 4'd0, 32'd16, 1'b1);
        send(3'd2, 4'd3, 4'd4, 4'd5, 4'd6, 32'd20);
        expect_uop("R4 store", 3'd2, 4'd0, 4'd0, 4'd5, 4'd6, 32'd20, 1'b1);
    endtask

    task automatic t_mem_src();
        send(3'd3, 4'd2, 4'd8, 4'd9, 4'd10, 32'd40);
        expect_uop("R5 load tmp", 3'd1, 4'd0, T, 4'd9, 4'd0, 32'd40, 1'b0);
        expect_uop("R5 alu", 3'd0, 4'd2, 4'd8, 4'd8, T, 32'd0, 1'b1);
    endtask

    task automatic t_mem_dst_stall();
        send(3'd4, 4'd6, 4'd1, 4'd3, 4'd11, 32'd8);
        expect_uop("R6 load tmp", 3'd1, 4'd0, T, 4'd3, 4'd0, 32'd8, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 stall hold", {12'd0, out_valid, out_op, out_rd, out_ra, out_rb, out_eoi},
                                  {12'd0, 1'b1, 3'd0, T, T, 4'd11, 1'b0});
            chk("R2 ready low", 64'(in_ready), 64'd0);
        end
        expect_uop("R6 alu", 3'd0, 4'd6, T, T, 4'd11, 32'd0, 1'b0);
        expect_uop("R6 store", 3'd2, 4'd0, 4'd0, 4'd3, T, 32'd8, 1'b1);
        @(negedge clk);
        chk("R2 ready back", 64'(in_ready), 64'd1);
    endtask

    task automatic t_push();
        send(3'd5, 4'd0, 4'd0, 4'd0, 4'd12, 32'd0);
        expect_uop("R7 store", 3'd2, 4'd0, 4'd0, SP, 4'd12, M4, 1'b0);
        expect_uop("R7 sp dec", 3'd3, 4'd0, SP, SP, 4'd0, M4, 1'b1);
    endtask

    task automatic t_call();
        send(3'd6, 4'd0, 4'd0, 4'd0, 4'd0, 32'h0000_8000);
        @(negedge clk);
        chk("R2 ready low call", 64'(in_ready), 64'd0);
        expect_uop("R8 pc cap", 3'd4, 4'd0, T, 4'd0, 4'd0, 32'd0, 1'b0);
        expect_uop("R8 store", 3'd2, 4'd0, 4'd0, SP, T, M4, 1'b0);
        expect_uop("R8 sp dec", 3'd3, 4'd0, SP, SP, 4'd0, M4, 1'b0);
        expect_uop("R8 jmp", 3'd5, 4'd0, 4'd0, 4'd0, 4'd0, 32'h0000_8000, 1'b1);
    endtask

    task automatic t_ret();
        send(3'd7, 4'd0, 4'd0, 4'd0, 4'd0, 32'd0);
        expect_uop("R9 sp inc", 3'd3, 4'd0, SP, SP, 4'd0, P4, 1'b0);
        expect_uop("R9 load ra", 3'd1, 4'd0, T, SP, 4'd0, M4, 1'b0);
        expect_uop("R9 R12 jmpr", 3'd6, 4'd0, 4'd0, T, 4'd0, 32'd0, 1'b1);
        @(negedge clk);
        chk("R11 idle after eoi", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_reg_alu();
        t_load_store();
        t_mem_src();
        t_mem_dst_stall();
        t_push();
        t_call();
        t_ret();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule